// File: doc/BRIEF.md
# Streaming Max-Pooling Layer

This block reduces a three-dimensional feature volume that arrives one element at a time over a ready/valid stream. It takes in one full input frame and stores it locally. It then moves a rectangular window over the X-Y plane, with separate sizes and steps on each axis. For every window position and every depth slice it produces the largest signed value inside the window. The results leave on a second ready/valid stream. They use the same scan order as the input: X changes slowest, then Y, and depth changes fastest. The final result of a frame is flagged.

The block sits between neighbouring layers of an inference pipeline that all use this scan order. The frame sizes, window sizes, steps and data width are fixed when the block is built. There is no padding, so window positions that would run past the frame edge are dropped. The depth of the output equals the depth of the input. Elements are handled one at a time. The block accepts no input while it is reducing a stored frame.

Top module: `pool_layer`

## Requirements
- R1: After reset, and again after a reset that interrupts a partially loaded frame, `in_ready` is 1 and `out_valid` is 0, and the next frame is loaded starting from its first element.
- R2: Each input frame of IN_X*IN_Y*IN_Z elements produces exactly OUT_X*OUT_Y*IN_Z outputs, where OUT_X = (IN_X-KERN_X)/STRIDE_X+1 and OUT_Y = (IN_Y-KERN_Y)/STRIDE_Y+1, rounded down.
- R3: The output for window position (ox, oy) at depth z is the signed two's-complement maximum of input(x, y, z) over x = ox*STRIDE_X .. ox*STRIDE_X+KERN_X-1 and y = oy*STRIDE_Y .. oy*STRIDE_Y+KERN_Y-1.
- R4: Input element k is input(x, y, z) with k = (x*IN_Y + y)*IN_Z + z. Output element j is the result for (ox, oy, z) with j = (ox*OUT_Y + oy)*IN_Z + z.
- R5: `out_last` is 1 on the final output of a frame and 0 on every other output.
- R6: `in_ready` stays 0 from the acceptance of a frame's last input until the handshake of that frame's last output. Data offered on `in_valid` during that time is ignored.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold steady.
- R8: With `out_ready` held at 1, each output handshake comes exactly KERN_X*KERN_Y+1 cycles after the previous handshake. For the first output of a frame, the count starts from the frame's last input handshake.
- R9: An input element is taken only on a cycle where both `in_valid` and `in_ready` are 1. Gaps in `in_valid` do not shift the stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input element offered |
| in_ready | output | 1 | Block can take an input element |
| in_data | input | DATA_W | Input element, signed |
| out_valid | output | 1 | Output element offered |
| out_ready | input | 1 | Downstream takes the output element |
| out_data | output | DATA_W | Pooled element, signed |
| out_last | output | 1 | Marks the last output of a frame |

## Verification
The bench builds the block with an input volume of 6 by 4 by 2, a window of 3 by 2, and steps of 2 in X and 1 in Y. This yields an output of 2 by 3 by 2. The window is not square and the two steps differ, so swapping the X and Y axes or their parameters gives wrong values. IN_X is chosen so that the last input column falls outside every window, which exercises the rounding down of the output width. The depth of 2 shows whether the window mixes depth slices. The 6-cycle window scan makes the per-output cycle count distinctive enough to catch an off-by-one in the sequencer.

// File: rtl/pool_pkg.sv
package pool_pkg;

  typedef enum logic [1:0] {
    PS_LOAD = 2'd0,
    PS_SCAN = 2'd1,
    PS_EMIT = 2'd2
  } pool_state_e;

  // counter width able to hold 0 .. n-1, never zero bits
  function automatic int cw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pool_frame_buf.sv
module pool_frame_buf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int AW     = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // storage only, no reset needed: every word is written before it is read
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/pool_window_seq.sv
module pool_window_seq #(
  parameter int IN_Y     = 4,
  parameter int IN_Z     = 2,
  parameter int KERN_X   = 2,
  parameter int KERN_Y   = 2,
  parameter int STRIDE_X = 2,
  parameter int STRIDE_Y = 2,
  parameter int OUT_X    = 2,
  parameter int OUT_Y    = 2,
  parameter int AW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_scan,
  input  logic          step_emit,
  output logic [AW-1:0] rd_addr,
  output logic          win_first,
  output logic          win_done,
  output logic          elem_last
);

  localparam int KXW = pool_pkg::cw(KERN_X);
  localparam int KYW = pool_pkg::cw(KERN_Y);
  localparam int OXW = pool_pkg::cw(OUT_X);
  localparam int OYW = pool_pkg::cw(OUT_Y);
  localparam int OZW = pool_pkg::cw(IN_Z);

  logic [KXW-1:0] kx_q, kx_nxt;
  logic [KYW-1:0] ky_q, ky_nxt;
  logic [OXW-1:0] ox_q, ox_nxt;
  logic [OYW-1:0] oy_q, oy_nxt;
  logic [OZW-1:0] oz_q, oz_nxt;

  logic kx_end, ky_end, ox_end, oy_end, oz_end;
  logic [31:0] x_pos, y_pos, lin;

  assign kx_end = (kx_q == KXW'(KERN_X - 1));
  assign ky_end = (ky_q == KYW'(KERN_Y - 1));
  assign ox_end = (ox_q == OXW'(OUT_X - 1));
  assign oy_end = (oy_q == OYW'(OUT_Y - 1));
  assign oz_end = (oz_q == OZW'(IN_Z - 1));

  assign win_first = (kx_q == '0) && (ky_q == '0);
  assign win_done  = kx_end && ky_end;
  assign elem_last = ox_end && oy_end && oz_end;

  // window walk: X outer, Y inner; wraps to the origin on its last cycle
  always_comb begin
    kx_nxt = kx_q;
    ky_nxt = ky_q;
    if (step_scan) begin
      if (ky_end) begin
        ky_nxt = '0;
        kx_nxt = kx_end ? '0 : kx_q + 1'b1;
      end else begin
        ky_nxt = ky_q + 1'b1;
      end
    end
  end

  // output walk: X outer, Y next, depth innermost
  always_comb begin
    ox_nxt = ox_q;
    oy_nxt = oy_q;
    oz_nxt = oz_q;
    if (step_emit) begin
      if (oz_end) begin
        oz_nxt = '0;
        if (oy_end) begin
          oy_nxt = '0;
          ox_nxt = ox_end ? '0 : ox_q + 1'b1;
        end else begin
          oy_nxt = oy_q + 1'b1;
        end
      end else begin
        oz_nxt = oz_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kx_q <= '0;
      ky_q <= '0;
    end else if (step_scan) begin
      kx_q <= kx_nxt;
      ky_q <= ky_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ox_q <= '0;
      oy_q <= '0;
      oz_q <= '0;
    end else if (step_emit) begin
      ox_q <= ox_nxt;
      oy_q <= oy_nxt;
      oz_q <= oz_nxt;
    end
  end

  always_comb begin
    x_pos = 32'(ox_q) * 32'(STRIDE_X) + 32'(kx_q);
    y_pos = 32'(oy_q) * 32'(STRIDE_Y) + 32'(ky_q);
    lin   = (x_pos * 32'(IN_Y) + y_pos) * 32'(IN_Z) + 32'(oz_q);
  end

  assign rd_addr = lin[AW-1:0];

endmodule

// File: rtl/pool_max_acc.sv
module pool_max_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              first,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] acc
);

  logic signed [DATA_W-1:0] acc_q, acc_nxt, din_s;

  assign din_s = $signed(din);

  always_comb begin
    if (first) begin
      acc_nxt = din_s;
    end else if (din_s > acc_q) begin
      acc_nxt = din_s;
    end else begin
      acc_nxt = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      acc_q <= acc_nxt;
    end
  end

  assign acc = acc_q;

endmodule

// File: rtl/pool_layer.sv
module pool_layer #(
  parameter int IN_X     = 8,
  parameter int IN_Y     = 8,
  parameter int IN_Z     = 4,
  parameter int KERN_X   = 2,
  parameter int KERN_Y   = 2,
  parameter int STRIDE_X = 2,
  parameter int STRIDE_Y = 2,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last
);

  import pool_pkg::*;

  localparam int IN_T  = IN_X * IN_Y * IN_Z;
  localparam int OUT_X = (IN_X - KERN_X) / STRIDE_X + 1;
  localparam int OUT_Y = (IN_Y - KERN_Y) / STRIDE_Y + 1;
  localparam int AW    = cw(IN_T);

  pool_state_e state_q, state_nxt;
  logic [AW-1:0] wr_addr_q, wr_addr_nxt;
  logic [AW-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data, acc;
  logic in_fire, load_end, step_scan, step_emit;
  logic win_first, win_done, elem_last;

  assign in_ready  = (state_q == PS_LOAD);
  assign in_fire   = in_valid && in_ready;
  assign load_end  = in_fire && (wr_addr_q == AW'(IN_T - 1));
  assign step_scan = (state_q == PS_SCAN);
  assign step_emit = (state_q == PS_EMIT) && out_ready;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      PS_LOAD: if (load_end) state_nxt = PS_SCAN;
      PS_SCAN: if (win_done) state_nxt = PS_EMIT;
      PS_EMIT: if (out_ready) state_nxt = elem_last ? PS_LOAD : PS_SCAN;
      default: state_nxt = PS_LOAD;
    endcase
  end

  always_comb begin
    wr_addr_nxt = wr_addr_q;
    if (in_fire) begin
      wr_addr_nxt = load_end ? '0 : wr_addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_LOAD;
    end else begin
      state_q <= state_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
    end else if (in_fire) begin
      wr_addr_q <= wr_addr_nxt;
    end
  end

  pool_frame_buf #(
    .DEPTH (IN_T),
    .DATA_W(DATA_W),
    .AW    (AW)
  ) u_buf (
    .clk    (clk),
    .wr_en  (in_fire),
    .wr_addr(wr_addr_q),
    .wr_data(in_data),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  pool_window_seq #(
    .IN_Y    (IN_Y),
    .IN_Z    (IN_Z),
    .KERN_X  (KERN_X),
    .KERN_Y  (KERN_Y),
    .STRIDE_X(STRIDE_X),
    .STRIDE_Y(STRIDE_Y),
    .OUT_X   (OUT_X),
    .OUT_Y   (OUT_Y),
    .AW      (AW)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_scan(step_scan),
    .step_emit(step_emit),
    .rd_addr  (rd_addr),
    .win_first(win_first),
    .win_done (win_done),
    .elem_last(elem_last)
  );

  pool_max_acc #(
    .DATA_W(DATA_W)
  ) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (step_scan),
    .first(win_first),
    .din  (rd_data),
    .acc  (acc)
  );

  assign out_valid = (state_q == PS_EMIT);
  assign out_data  = acc;
  assign out_last  = (state_q == PS_EMIT) && elem_last;

endmodule

// File: rtl/pool_layer_chk.sv
module pool_layer_chk #(
  parameter int IN_X     = 8,
  parameter int IN_Y     = 8,
  parameter int IN_Z     = 4,
  parameter int KERN_X   = 2,
  parameter int KERN_Y   = 2,
  parameter int STRIDE_X = 2,
  parameter int STRIDE_Y = 2,
  parameter int DATA_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last
);

  localparam int OUT_T = ((IN_X - KERN_X) / STRIDE_X + 1) *
                         ((IN_Y - KERN_Y) / STRIDE_Y + 1) * IN_Z;

  int unsigned hs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_cnt <= 0;
    end else if (out_valid && out_ready) begin
      hs_cnt <= out_last ? 0 : hs_cnt + 1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R6

  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R5

  AST_LAST_AT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_last == (hs_cnt == OUT_T - 1))); // R2

  AST_SCAN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> !out_valid); // R8

  AST_LOAD_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R6

  logic unused_ok;
  assign unused_ok = in_valid;

endmodule

bind pool_layer pool_layer_chk #(
  .IN_X    (IN_X),
  .IN_Y    (IN_Y),
  .IN_Z    (IN_Z),
  .KERN_X  (KERN_X),
  .KERN_Y  (KERN_Y),
  .STRIDE_X(STRIDE_X),
  .STRIDE_Y(STRIDE_Y),
  .DATA_W  (DATA_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_last (out_last)
);

// File: tb/pool_layer_test.sv
`timescale 1ns/1ps
module pool_layer_test;

  localparam int IN_X = 6, IN_Y = 4, IN_Z = 2;
  localparam int KX = 3, KY = 2, SX = 2, SY = 1, DW = 8;
  localparam int OUT_X = (IN_X - KX) / SX + 1;
  localparam int OUT_Y = (IN_Y - KY) / SY + 1;
  localparam int IN_T  = IN_X * IN_Y * IN_Z;
  localparam int OUT_T = OUT_X * OUT_Y * IN_Z;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready, out_last;
  logic [DW-1:0] in_data, out_data;

  always #4 clk = ~clk;

  pool_layer #(
    .IN_X(IN_X), .IN_Y(IN_Y), .IN_Z(IN_Z),
    .KERN_X(KX), .KERN_Y(KY), .STRIDE_X(SX), .STRIDE_Y(SY), .DATA_W(DW)
  ) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_in_cyc = 0;
  bit done = 0;
  int fr [IN_T];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_max(input int ox, input int oy, input int z);
    int m = 0;
    for (int kx = 0; kx < KX; kx++) begin
      for (int ky = 0; ky < KY; ky++) begin
        int v = fr[((ox * SX + kx) * IN_Y + (oy * SY + ky)) * IN_Z + z];
        if ((kx == 0 && ky == 0) || v > m) m = v;
      end
    end
    return m;
  endfunction

  task automatic fill(input int mode, input int seed);
    int s = seed;
    for (int i = 0; i < IN_T; i++) begin
      case (mode)
        0: fr[i] = i - 20;
        1: begin
          s = (s * 1103515245 + 12345) & 32'h7fffffff;
          fr[i] = ((s >> 8) & 255) - 128;
        end
        default: fr[i] = -128;
      endcase
    end
  endtask

  task automatic send_frame(input bit gaps);
    for (int i = 0; i < IN_T; i++) begin
      @(negedge clk);
      if (gaps && (i % 3 == 1)) begin
        in_valid = 1'b0;
        in_data  = 8'h7f;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = fr[i][DW-1:0];
      while (!in_ready) @(negedge clk);
      last_in_cyc = cyc + 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv_frame(input bit stall, input bit junk, input bit timed);
    int idx = 0;
    int guard = 0;
    int last_hs = last_in_cyc;
    bit hold = 0;
    logic [DW-1:0] hd = '0;
    logic hl = 1'b0;
    while (idx < OUT_T && guard < 2000) begin
      bit rdy;
      guard++;
      @(negedge clk);
      if (junk) begin
        in_valid = 1'b1;
        in_data  = 8'h7f;
      end
      rdy = stall ? ((cyc % 3) != 0) : 1'b1;
      out_ready = rdy;
      if (hold) begin
        chk(out_valid && out_data == hd && out_last == hl, "R7", "held output",
            int'(out_data), int'(hd));
        hold = 0;
      end
      if (out_valid) chk(!in_ready, "R6", "in_ready while emitting", in_ready, 0);
      if (out_valid && rdy) begin
        int z = idx % IN_Z;
        int oy = (idx / IN_Z) % OUT_Y;
        int ox = idx / (IN_Z * OUT_Y);
        int e = ref_max(ox, oy, z);
        chk($signed(out_data) == e, "R3", $sformatf("value R4 idx %0d", idx),
            $signed(out_data), e);
        chk(out_last == (idx == OUT_T - 1), "R5", "last marker", out_last,
            idx == OUT_T - 1);
        if (timed) chk(cyc + 1 - last_hs == KX * KY + 1, "R8", "cycles per output",
                       cyc + 1 - last_hs, KX * KY + 1);
        last_hs = cyc + 1;
        if (out_last) in_valid = 1'b0;
        idx++;
      end else if (out_valid) begin
        hold = 1;
        hd = out_data;
        hl = out_last;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    chk(idx == OUT_T, "R2", "output count", idx, OUT_T);
    chk(!out_valid && in_ready, "R2", "idle after frame", out_valid, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_ramp_timed();
    fill(0, 0);
    send_frame(0);
    recv_frame(0, 0, 1);
  endtask

  task automatic t_random_stalls();
    fill(1, 7);
    send_frame(1);  // R9 input gaps
    recv_frame(1, 0, 0);
  endtask

  task automatic t_busy_junk();
    fill(2, 0);
    send_frame(0);
    recv_frame(0, 1, 1);
    fill(1, 99);  // R6 junk from the busy window must not have entered
    send_frame(0);
    recv_frame(0, 0, 1);
  endtask

  task automatic t_mid_reset();
    fill(1, 3);
    for (int i = 0; i < IN_T / 2; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 8'h7f;
    end
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1", "state after mid-frame reset",
        in_ready, 1);
    send_frame(1);
    recv_frame(1, 1, 0);
  endtask

  initial begin
    t_reset();
    t_ramp_timed();
    t_random_stalls();
    t_busy_junk();
    t_mid_reset();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule